// File: doc/BRIEF.md
# Asynchronous Static-Memory Bus Controller

This controller connects a plain valid/ready request port to a 16-bit asynchronous memory or memory-mapped peripheral. Each request carries a byte address, a write flag, write data and byte enables. The controller runs it on the external pins as three timed phases: address setup, strobe and hold. A turnaround gap follows before the next request is taken. Reads and writes each have their own setup, strobe and hold lengths, all taken from one 32-bit configuration word.

Two modes change the pin behaviour. In strobe mode the chip select acts as a second strobe and is asserted only in the strobe phase. In extended-wait mode an external wait pin, with a selectable active level, can stretch the strobe phase. Addressing is by 32-bit word, with a separate halfword-select pin for the 16-bit device. The external word-address bit n is therefore internal byte-address bit n+2, and byte-address bit 1 drives the halfword select.

The configuration word must be held constant while an access is in progress. Its two lowest bits (bus size) are not used, because the data path is always 16 bits. The wait pin is sampled on the controller clock and must already be synchronous to it.

Top module: `xbus_async_ctrl`

## Requirements
- R1: While reset is active and after reset, all of these hold until a request arrives: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_bmask_n` is all ones, `mem_dq_oe` is low, `rsp_done` is low and `req_ready` is high.
- R2: For an accepted request, `mem_addr` equals byte address bits [ADDR_W-1:2] and `mem_hsel` equals byte address bit 1. Both stay stable for the whole access.
- R3: The configuration word is decoded as follows:
  - bit 31: strobe mode
  - bit 30: extended wait
  - [29:26]: write setup
  - [25:20]: write strobe
  - [19:17]: write hold
  - [16:13]: read setup
  - [12:7]: read strobe
  - [6:4]: read hold
  - [3:2]: turnaround
  
  Each phase lasts its field value plus one clock. A read uses only the read fields and a write uses only the write fields.
- R4: Outside strobe mode, `mem_cs_n` is low for the whole of setup, strobe and hold. `mem_oe_n` (read) or `mem_we_n` (write) is low only during the strobe phase, and the other enable stays high.
- R5: In strobe mode, `mem_cs_n` is low in exactly the cycles in which the read or write enable is low.
- R6: During setup, strobe and hold, `mem_bmask_n` equals the inverted byte enables. Outside an access it is all ones.
- R7: For a write, `mem_dq_oe` is high from the first setup cycle to the last hold cycle, and `mem_dq_out` carries the write data. `mem_dq_oe` is low during reads, turnaround and idle.
- R8: A read returns on `rsp_rdata` the value of `mem_dq_in` at the last strobe cycle.
- R9: `rsp_done` is a single-cycle pulse in the first cycle after hold ends. `req_ready` is high only when idle, which is turnaround+1 cycles after hold ends.
- R10: With extended wait enabled, the strobe phase ends at the later of two points:
  - its programmed end;
  - the first cycle in which `mem_wait` differs from `wait_act_hi`.
  
  So it never ends while the wait pin is active. With extended wait disabled, `mem_wait` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Timing and mode configuration |
| wait_act_hi | input | 1 | Active level of `mem_wait` (1 = high) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle access completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable (write strobe), active low |
| mem_bmask_n | output | DATA_W/8 | Byte-lane masks, active low |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_hsel | output | 1 | Halfword select |
| mem_dq_out | output | DATA_W | Data driven to the device |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | Data from the device |
| mem_wait | input | 1 | External wait |

## Verification
The bench sweeps four dimensions at once:
- setup, strobe, hold and turnaround values;
- both directions;
- both chip-select modes;
- addresses, byte enables and data.

For each access it measures every pin window against cycle counts computed from the field values. The unused direction's fields are always programmed differently, so a read that wrongly takes write timing shows up as a wrong window length.

During reads, the input data bus changes every cycle, so a capture one cycle early or late returns the wrong value. Wait patterns end before, at and after the programmed strobe end, with both polarities, and with the mode disabled. This separates correct stretching from ignoring the pin, inverting it or cutting the strobe short.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  // Packed layout matches the configuration word bit for bit (MSB first).
  typedef struct packed {
    logic       cs_strobe;   // 31
    logic       ext_wait;    // 30
    logic [3:0] wr_setup;    // 29:26
    logic [5:0] wr_strobe;   // 25:20
    logic [2:0] wr_hold;     // 19:17
    logic [3:0] rd_setup;    // 16:13
    logic [5:0] rd_strobe;   // 12:7
    logic [2:0] rd_hold;     // 6:4
    logic [1:0] turn;        // 3:2
    logic [1:0] bus_size;    // 1:0 (not used, bus is 16 bit)
  } timing_t;

  localparam int CNT_W = 6;

  // Counter reload when entering a phase: a phase lasts reload+1 cycles.
  function automatic logic [CNT_W-1:0] phase_reload(timing_t c, logic wr, phase_e ph);
    logic [CNT_W-1:0] v;
    case (ph)
      PH_SETUP:  v = wr ? {2'b00, c.wr_setup} : {2'b00, c.rd_setup};
      PH_STROBE: v = wr ? c.wr_strobe : c.rd_strobe;
      PH_HOLD:   v = wr ? {3'b000, c.wr_hold} : {3'b000, c.rd_hold};
      PH_TURN:   v = {4'b0000, c.turn};
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/xbus_phase_seq.sv
module xbus_phase_seq
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  timing_t cfg,
  input  logic    start,
  input  logic    start_wr,
  input  logic    wait_hit,
  output phase_e  phase,
  output logic    cur_wr,
  output logic    strobe_last,
  output logic    done_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic             hold_last;

  assign cnt_zero    = (cnt_q == '0);
  assign strobe_last = (phase == PH_STROBE) && cnt_zero && !wait_hit;
  assign hold_last   = (phase == PH_HOLD) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt_q      <= '0;
      cur_wr     <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= hold_last;
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          cur_wr <= start_wr;
          cnt_q  <= phase_reload(cfg, start_wr, PH_SETUP);
        end
        PH_SETUP: if (cnt_zero) begin
          phase <= PH_STROBE;
          cnt_q <= phase_reload(cfg, cur_wr, PH_STROBE);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (strobe_last) begin
          phase <= PH_HOLD;
          cnt_q <= phase_reload(cfg, cur_wr, PH_HOLD);
        end else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          phase <= PH_TURN;
          cnt_q <= phase_reload(cfg, cur_wr, PH_TURN);
        end else cnt_q <= cnt_q - 1'b1;
        PH_TURN: if (cnt_zero) phase <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [WA_W-1:0]   word_addr,
  output logic              half_sel,
  output logic [BE_W-1:0]   be_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic unused_byte_bit;
  assign unused_byte_bit = addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr <= '0;
      half_sel  <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (take) begin
        word_addr <= addr[ADDR_W-1:2];
        half_sel  <= addr[1];
        be_q      <= be;
        wdata_q   <= wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/xbus_pin_decode.sv
module xbus_pin_decode
  import xbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  phase_e            phase,
  input  logic              cur_wr,
  input  logic              cs_strobe,
  input  logic [BE_W-1:0]   be_q,
  output logic              access_on,
  output logic              strobe_on,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [BE_W-1:0]   bmask_n,
  output logic              dq_oe
);
  always_comb begin
    access_on = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strobe_on = (phase == PH_STROBE);
    cs_n      = !(cs_strobe ? strobe_on : access_on);
    oe_n      = !(strobe_on && !cur_wr);
    we_n      = !(strobe_on && cur_wr);
    bmask_n   = access_on ? ~be_q : '1;
    dq_oe     = access_on && cur_wr;
  end
endmodule

// File: rtl/xbus_async_ctrl.sv
module xbus_async_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              wait_act_hi,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BE_W-1:0]   mem_bmask_n,
  output logic [WA_W-1:0]   mem_addr,
  output logic              mem_hsel,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_wait
);
  timing_t cfg;
  phase_e  phase;
  logic    cur_wr, strobe_last, accept, wait_hit;
  logic    access_on, strobe_on;
  logic [BE_W-1:0] be_q;
  logic    unused_size;

  assign cfg         = timing_t'(cfg_word);
  assign unused_size = ^cfg.bus_size;
  assign req_ready   = (phase == PH_IDLE);
  assign accept      = req_valid && req_ready;
  assign wait_hit    = cfg.ext_wait && (mem_wait == wait_act_hi);

  xbus_phase_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .start(accept), .start_wr(req_we),
    .wait_hit(wait_hit), .phase(phase), .cur_wr(cur_wr),
    .strobe_last(strobe_last), .done_pulse(rsp_done)
  );

  xbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .take(accept), .addr(req_addr), .be(req_be),
    .wdata(req_wdata), .capture(strobe_last && !cur_wr), .dq_in(mem_dq_in),
    .word_addr(mem_addr), .half_sel(mem_hsel), .be_q(be_q),
    .wdata_q(mem_dq_out), .rdata_q(rsp_rdata)
  );

  xbus_pin_decode #(.DATA_W(DATA_W)) pins_i (
    .phase(phase), .cur_wr(cur_wr), .cs_strobe(cfg.cs_strobe), .be_q(be_q),
    .access_on(access_on), .strobe_on(strobe_on), .cs_n(mem_cs_n),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .bmask_n(mem_bmask_n), .dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/xbus_async_ctrl_chk.sv
module xbus_async_ctrl_chk #(
  parameter int WA_W = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_strobe_mode,
  input logic            access_on,
  input logic            strobe_on,
  input logic            wait_hit,
  input logic            req_ready,
  input logic            rsp_done,
  input logic            mem_cs_n,
  input logic            mem_oe_n,
  input logic            mem_we_n,
  input logic            mem_dq_oe,
  input logic [WA_W-1:0] mem_addr,
  input logic            mem_hsel
);
  a_r4_enable_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  a_r4_one_enable_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r5_select_is_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_strobe_mode && !mem_cs_n) |-> (!mem_oe_n || !mem_we_n));

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r10_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && wait_hit) |=> strobe_on);

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    access_on |=> (!access_on || ($stable(mem_addr) && $stable(mem_hsel))));
endmodule

bind xbus_async_ctrl xbus_async_ctrl_chk #(.WA_W(WA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_strobe_mode(cfg.cs_strobe),
  .access_on(access_on), .strobe_on(strobe_on), .wait_hit(wait_hit),
  .req_ready(req_ready), .rsp_done(rsp_done), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .mem_addr(mem_addr), .mem_hsel(mem_hsel)
);

// File: tb/xbus_async_ctrl_tb.sv
module xbus_async_ctrl_tb_top;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic wait_act_hi = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] mem_dq_in = '0;
  logic mem_wait = 1'b0;
  logic req_ready, rsp_done, mem_cs_n, mem_oe_n, mem_we_n, mem_hsel, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out;
  logic [1:0] mem_bmask_n;
  logic [ADDR_W-3:0] mem_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xbus_async_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .wait_act_hi(wait_act_hi),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bmask_n(mem_bmask_n),
    .mem_addr(mem_addr), .mem_hsel(mem_hsel), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit sm, input bit ew, input int ws, input int wst,
      input int wh, input int rs, input int rst, input int rh, input int ta);
    logic [31:0] c;
    c = '0;
    c[31] = sm; c[30] = ew;
    c[29:26] = 4'(ws); c[25:20] = 6'(wst); c[19:17] = 3'(wh);
    c[16:13] = 4'(rs); c[12:7] = 6'(rst); c[6:4] = 3'(rh);
    c[3:2] = 2'(ta); c[1:0] = 2'b01;
    return c;
  endfunction

  // One access; wait pin active for cycles 1..wact (cycle 1 = first setup cycle).
  task automatic run_access(input logic [31:0] c, input bit wr, input logic [ADDR_W-1:0] a,
      input logic [1:0] be, input logic [15:0] wd, input int wact, input bit pol);
    int S, T, H, A, L, kd, kr;
    int cs_f, cs_l, cs_c, sb_f, sb_l, sb_c, oe_f, oe_l, oe_c, dn_c, dn_k, wrong_en;
    S = wr ? int'(c[29:26]) : int'(c[16:13]);
    T = wr ? int'(c[25:20]) : int'(c[12:7]);
    H = wr ? int'(c[19:17]) : int'(c[6:4]);
    A = int'(c[3:2]);
    L = S + T + 2;
    if (c[30] && (wact + 1 > L)) L = wact + 1;
    kd = L + H + 2;
    kr = L + H + A + 3;
    cs_f = 0; cs_l = 0; cs_c = 0; sb_f = 0; sb_l = 0; sb_c = 0;
    oe_f = 0; oe_l = 0; oe_c = 0; dn_c = 0; dn_k = 0; wrong_en = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_word = c; wait_act_hi = pol; mem_wait = !pol;
    req_we = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~wd;
    for (int k = 1; k <= kr; k++) begin
      if (!mem_cs_n) begin if (cs_c == 0) cs_f = k; cs_l = k; cs_c++; end
      if (wr ? !mem_we_n : !mem_oe_n) begin if (sb_c == 0) sb_f = k; sb_l = k; sb_c++; end
      if (wr ? !mem_oe_n : !mem_we_n) wrong_en++;
      if (mem_dq_oe) begin if (oe_c == 0) oe_f = k; oe_l = k; oe_c++; end
      if (rsp_done) begin dn_c++; dn_k = k; end
      if (k == S + 2) begin
        check(mem_addr == a[ADDR_W-1:2], "R2 word address", int'(mem_addr), int'(a[ADDR_W-1:2]));
        check(mem_hsel == a[1], "R2 halfword select", int'(mem_hsel), int'(a[1]));
        check(mem_bmask_n == ~be, "R6 byte mask in access", int'(mem_bmask_n), int'(~be));
        if (wr) check(mem_dq_out == wd, "R7 write data", int'(mem_dq_out), int'(wd));
      end
      if (k == kr - 1) check(!req_ready, "R9 busy in turnaround", int'(req_ready), 0);
      if (k == kd && !wr) check(rsp_rdata == (16'hA000 ^ 16'(L)), "R8 read capture",
                                int'(rsp_rdata), int'(16'hA000 ^ 16'(L)));
      mem_dq_in = 16'hA000 ^ 16'(k);
      mem_wait = (k <= wact) ? pol : !pol;
      @(negedge clk);
    end
    check(req_ready, "R9 ready after turnaround", int'(req_ready), 1);
    check(mem_bmask_n == 2'b11, "R6 mask idle", int'(mem_bmask_n), 3);
    check(sb_f == S + 2 && sb_l == L && sb_c == L - S - 1, "R3 R10 strobe window",
          sb_f * 1000 + sb_l, (S + 2) * 1000 + L);
    check(wrong_en == 0, "R4 other enable high", wrong_en, 0);
    if (c[31]) check(cs_f == sb_f && cs_l == sb_l && cs_c == sb_c, "R5 select follows strobe",
                     cs_f * 1000 + cs_l, sb_f * 1000 + sb_l);
    else check(cs_f == 1 && cs_l == L + H + 1 && cs_c == L + H + 1, "R4 select window",
               cs_f * 1000 + cs_l, 1000 + L + H + 1);
    if (wr) check(oe_f == 1 && oe_l == L + H + 1 && oe_c == L + H + 1, "R7 drive window",
                  oe_f * 1000 + oe_l, 1000 + L + H + 1);
    else check(oe_c == 0, "R7 no drive on read", oe_c, 0);
    check(dn_c == 1 && dn_k == kd, "R9 done pulse", dn_c * 1000 + dn_k, 1000 + kd);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    int su_v[3] = '{0, 1, 3};
    int st_v[3] = '{0, 2, 5};
    int hd_v[2] = '{0, 2};
    int ta_v[2] = '{0, 3};
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset", int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_bmask_n == 2'b11 && !mem_dq_oe, "R1 mask and drive", int'({mem_bmask_n, mem_dq_oe}), 6);
    check(req_ready && !rsp_done, "R1 ready idle", int'({req_ready, rsp_done}), 2);
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle", int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);

    idx = 0;
    for (int sm = 0; sm < 2; sm++)
      for (int wr = 0; wr < 2; wr++)
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++)
            for (int h = 0; h < 2; h++)
              for (int t = 0; t < 2; t++) begin
                logic [31:0] c;
                // R3: unused direction's fields deliberately differ
                if (wr == 1) c = mk_cfg(sm[0], 1'b0, su_v[i], st_v[j], hd_v[h],
                                        su_v[2-i] + 4, st_v[2-j] + 7, 7 - hd_v[h], ta_v[t]);
                else c = mk_cfg(sm[0], 1'b0, su_v[2-i] + 4, st_v[2-j] + 7, 7 - hd_v[h],
                                su_v[i], st_v[j], hd_v[h], ta_v[t]);
                idx++;
                run_access(c, wr[0], 24'(idx * 24'h01357B), 2'(idx), 16'(idx * 16'h3A5), 0, 1'b1);
              end

    // R10: extended wait, both polarities, release before/at/after programmed end
    for (int pol = 0; pol < 2; pol++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w < 5; w++) begin
          int wl[5] = '{0, 3, 5, 6, 11};
          logic [31:0] c;
          c = mk_cfg(w[0], 1'b1, 1, 3, 1, 1, 3, 1, 1);
          run_access(c, wr[0], 24'h00ABC6 + 24'(w * 4), 2'b10, 16'h5A5A, wl[w], pol[0]);
        end
    // R10: mode disabled, wait pin held active long
    run_access(mk_cfg(1'b0, 1'b0, 1, 2, 1, 1, 2, 1, 0), 1'b0, 24'h000012, 2'b01, 16'h0, 20, 1'b1);
    run_access(mk_cfg(1'b0, 1'b0, 1, 2, 1, 1, 2, 1, 0), 1'b1, 24'h000016, 2'b11, 16'h1234, 20, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule